// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector with Antibacklash Overlap

This block compares two streams of divider edges inside a synthesizable loop model. One stream comes from the reference divider and the other from the feedback divider. Both arrive as single-cycle strobes on a fast system clock. A reference edge raises the "pump up" flag and a feedback edge raises the "pump down" flag. The flag that rises first stays high until the other one rises, so the pulse width follows both the phase and the frequency error between the two streams.

When both flags are high, a common clear is started. It waits a programmable number of system clock cycles and then drops both flags together. This enforced overlap means that even a tiny phase error gives a pulse on each output. The loop therefore sees no dead zone around zero error.

The detector is a four-state machine:
- **IDLE**: both flags low.
- **UP_ONLY**: the reference led.
- **DN_ONLY**: the feedback led.
- **OVERLAP**: both flags high while the antibacklash timer runs.

The named transitions are:
- **lead-ref**: IDLE to UP_ONLY.
- **lead-fb**: IDLE to DN_ONLY.
- **catch**: UP_ONLY or DN_ONLY to OVERLAP.
- **coincide**: IDLE to OVERLAP, when both strobes arrive in one cycle.
- **release**: OVERLAP to IDLE.
- **release-rearm**: OVERLAP to UP_ONLY, DN_ONLY or OVERLAP. It is driven by edges held back during the overlap.

A strobe that arrives during OVERLAP is held, not lost. A polarity input exchanges the two outputs so the block can serve loops with inverted gain.

Top module: `pfd_core`

## Requirements
- R1: While the synchronous active-low reset is sampled low, the next cycle shows both outputs low and the timer cleared. This holds whatever state the block was in.
- R2: From IDLE, a reference strobe alone makes the up output high and the down output low in the cycle after the strobe is sampled.
- R3: From IDLE, a feedback strobe alone makes the down output high and the up output low in the cycle after the strobe is sampled.
- R4: Once both flags are high, they stay high together for exactly L cycles, where L is the overlap length input. They then both go low, unless an edge was held.
- R5: If the reference strobe leads the feedback strobe by d cycles, the up output is high for d+L cycles and the down output for L cycles. The mirror case holds when the feedback strobe leads.
- R6: Strobes on both inputs in the same cycle raise both outputs in the same next cycle. Both outputs then stay high for L cycles.
- R7: An overlap length of 0 acts as a length of 1.
- R8: A further reference strobe while only the up flag is high has no effect on either output. The same holds for a feedback strobe while only the down flag is high.
- R9: A strobe that arrives during OVERLAP is held. When the overlap ends, the block enters the state that the strobe would have caused from IDLE.
- R10: With the swap input high, the up output carries the feedback-led flag and the down output carries the reference-led flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_stb_i | input | 1 | Single-cycle edge strobe from the reference divider |
| fb_stb_i | input | 1 | Single-cycle edge strobe from the feedback divider |
| abl_len_i | input | CNT_W | Antibacklash overlap length in cycles (0 acts as 1) |
| swap_i | input | 1 | High exchanges the up and down outputs |
| up_o | output | 1 | Pump-up drive (source) |
| dn_o | output | 1 | Pump-down drive (sink) |

## Verification
The assertions assume that the overlap length input is held steady while both flags are high. The bound on the timer count relies on this. They also assume that each strobe is a clean synchronous pulse, so a new edge is a new edge. The directed tasks change the length only while the detector is in IDLE, and they drive each strobe high for a single cycle at a falling clock edge. The held-edge and repeated-edge cases place their extra strobes deliberately inside OVERLAP and inside a one-sided state.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Detector states: which flags are currently raised
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_UP_ONLY = 2'd1,
        ST_DN_ONLY = 2'd2,
        ST_OVERLAP = 2'd3
    } pfd_state_t;

    // Index of each input stream in the edge-hold array
    localparam int unsigned IDX_REF = 0;
    localparam int unsigned IDX_FB  = 1;
    localparam int unsigned N_STREAMS = 2;

endpackage

// File: rtl/pfd_edge_hold.sv
// Holds an edge that arrives while the common clear is still counting.
module pfd_edge_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic hold_i,
    output logic eff_o
);

    logic pend_q;
    logic pend_d;

    always_comb begin
        if (hold_i) begin
            pend_d = pend_q | stb_i;
        end else begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign eff_o = stb_i | pend_q;

endmodule

// File: rtl/pfd_abl_timer.sv
// Counts overlap cycles; flags the last one.
module pfd_abl_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] eff_len;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        eff_len = (len_i == '0) ? ONE : len_i;
        done_o  = run_i && (cnt_q == (eff_len - ONE));
        if (run_i && !done_o) begin
            cnt_d = cnt_q + ONE;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_eff_i,
    input  logic       fb_eff_i,
    input  logic       done_i,
    output pfd_state_t state_o,
    output logic       flag_up_o,
    output logic       flag_dn_o
);

    pfd_state_t state_q;
    pfd_state_t state_d;

    function automatic pfd_state_t from_idle(input logic r, input logic f);
        pfd_state_t s;
        unique case ({r, f})
            2'b11:   s = ST_OVERLAP;
            2'b10:   s = ST_UP_ONLY;
            2'b01:   s = ST_DN_ONLY;
            default: s = ST_IDLE;
        endcase
        return s;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = from_idle(ref_eff_i, fb_eff_i);
            ST_UP_ONLY: if (fb_eff_i)  state_d = ST_OVERLAP;
            ST_DN_ONLY: if (ref_eff_i) state_d = ST_OVERLAP;
            ST_OVERLAP: if (done_i)    state_d = from_idle(ref_eff_i, fb_eff_i);
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag_up_o = 1'b0;
        flag_dn_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_UP_ONLY: flag_up_o = 1'b1;
            ST_DN_ONLY: flag_dn_o = 1'b1;
            ST_OVERLAP: begin
                flag_up_o = 1'b1;
                flag_dn_o = 1'b1;
            end
            default:    ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_stb_i,
    input  logic             fb_stb_i,
    input  logic [CNT_W-1:0] abl_len_i,
    input  logic             swap_i,
    output logic             up_o,
    output logic             dn_o
);

    pfd_state_t       state;
    logic             in_ovl;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_cnt;
    logic             flag_up;
    logic             flag_dn;
    logic [N_STREAMS-1:0] stb_vec;
    logic [N_STREAMS-1:0] eff_vec;

    assign stb_vec[IDX_REF] = ref_stb_i;
    assign stb_vec[IDX_FB]  = fb_stb_i;
    assign in_ovl           = (state == ST_OVERLAP);

    for (genvar g = 0; g < N_STREAMS; g++) begin : g_hold
        pfd_edge_hold u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb_i  (stb_vec[g]),
            .hold_i (in_ovl && !tmr_done),
            .eff_o  (eff_vec[g])
        );
    end

    pfd_abl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (in_ovl),
        .len_i  (abl_len_i),
        .done_o (tmr_done),
        .cnt_o  (tmr_cnt)
    );

    pfd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_eff_i (eff_vec[IDX_REF]),
        .fb_eff_i  (eff_vec[IDX_FB]),
        .done_i    (tmr_done),
        .state_o   (state),
        .flag_up_o (flag_up),
        .flag_dn_o (flag_dn)
    );

    assign up_o = swap_i ? flag_dn : flag_up;
    assign dn_o = swap_i ? flag_up : flag_dn;

endmodule

// File: rtl/pfd_core_chk.sv
module pfd_core_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_stb_i,
    input logic             fb_stb_i,
    input logic [CNT_W-1:0] abl_len_i,
    input logic             flag_up,
    input logic             flag_dn,
    input logic [CNT_W-1:0] tmr_cnt
);

    logic [CNT_W-1:0] eff_len;
    assign eff_len = (abl_len_i == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : abl_len_i;

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!flag_up && !flag_dn && tmr_cnt == '0));

    a_r2_ref_raises_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_up && !flag_dn && ref_stb_i && !fb_stb_i) |=> (flag_up && !flag_dn));

    a_r3_fb_raises_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_up && !flag_dn && fb_stb_i && !ref_stb_i) |=> (flag_dn && !flag_up));

    a_r6_coincide: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_up && !flag_dn && fb_stb_i && ref_stb_i) |=> (flag_dn && flag_up));

    a_r8_up_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_up && !flag_dn) |=> flag_up);

    a_r8_dn_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_dn && !flag_up) |=> flag_dn);

    a_r4_overlap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_up && flag_dn) |-> (tmr_cnt < eff_len));

endmodule

bind pfd_core pfd_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_stb_i (ref_stb_i),
    .fb_stb_i  (fb_stb_i),
    .abl_len_i (abl_len_i),
    .flag_up   (flag_up),
    .flag_dn   (flag_dn),
    .tmr_cnt   (tmr_cnt)
);

// File: tb/pfd_core_tb.sv
module pfd_core_tb;

    localparam int unsigned CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_stb = 1'b0;
    logic             fb_stb = 1'b0;
    logic [CNT_W-1:0] abl_len = 8'd1;
    logic             swap = 1'b0;
    logic             up_o;
    logic             dn_o;

    int n_chk = 0;
    int n_bad = 0;
    int up_cnt;
    int dn_cnt;
    logic probe_up;
    logic probe_dn;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pfd_core #(.CNT_W(CNT_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_stb_i (ref_stb),
        .fb_stb_i  (fb_stb),
        .abl_len_i (abl_len),
        .swap_i    (swap),
        .up_o      (up_o),
        .dn_o      (dn_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive strobes at cycle indices ra/rb (ref) and fa (fb); -1 means none.
    // Counts samples of each output high over the window; records sample at probe.
    task automatic run_win(input int ra, input int rb, input int fa, input int fb2,
                           input int probe, input int len);
        abl_len  = len[CNT_W-1:0];
        up_cnt   = 0;
        dn_cnt   = 0;
        probe_up = 1'b0;
        probe_dn = 1'b0;
        for (int c = 0; c < 40; c++) begin
            ref_stb = (c == ra) || (c == rb);
            fb_stb  = (c == fa) || (c == fb2);
            @(negedge clk);
            if (up_o) up_cnt++;
            if (dn_o) dn_cnt++;
            if (c == probe) begin
                probe_up = up_o;
                probe_dn = dn_o;
            end
        end
        ref_stb = 1'b0;
        fb_stb  = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 up after reset", up_o, 0);
        check("R1 dn after reset", dn_o, 0);
        rst_n = 1'b1;
        ref_stb = 1'b1;
        @(negedge clk);
        ref_stb = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 up cleared mid-pulse", up_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_ref_lead();
        run_win(1, -1, 5, -1, 1, 3);
        check("R2 up first sample", probe_up, 1);
        check("R2 dn first sample", probe_dn, 0);
        check("R5 up width ref lead", up_cnt, 7);
        check("R4 dn width ref lead", dn_cnt, 3);
    endtask

    task automatic t_fb_lead();
        run_win(4, -1, 2, -1, 2, 2);
        check("R3 dn first sample", probe_dn, 1);
        check("R3 up first sample", probe_up, 0);
        check("R5 dn width fb lead", dn_cnt, 4);
        check("R4 up width fb lead", up_cnt, 2);
    endtask

    task automatic t_simul();
        run_win(3, -1, 3, -1, 3, 5);
        check("R6 up rises with dn", probe_up, 1);
        check("R6 dn rises with up", probe_dn, 1);
        check("R6 up width", up_cnt, 5);
        check("R6 dn width", dn_cnt, 5);
    endtask

    task automatic t_len_zero();
        run_win(0, -1, 0, -1, 0, 0);
        check("R7 up width len0", up_cnt, 1);
        check("R7 dn width len0", dn_cnt, 1);
    endtask

    task automatic t_repeat();
        run_win(0, 3, 6, -1, 4, 2);
        check("R8 dn low after repeat ref", probe_dn, 0);
        check("R8 up width", up_cnt, 8);
        check("R8 dn width", dn_cnt, 2);
    endtask

    task automatic t_pending();
        run_win(0, 3, 2, 8, 6, 4);
        check("R9 up after held edge", probe_up, 1);
        check("R9 dn after held edge", probe_dn, 0);
        check("R9 up total", up_cnt, 12);
        check("R9 dn total", dn_cnt, 8);
    endtask

    task automatic t_swap();
        swap = 1'b1;
        run_win(0, -1, 3, -1, 0, 2);
        check("R10 dn carries ref flag", probe_dn, 1);
        check("R10 up low first", probe_up, 0);
        check("R10 dn width", dn_cnt, 5);
        check("R10 up width", up_cnt, 2);
        swap = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        check("R1 up at reset", up_o, 0);
        check("R1 dn at reset", dn_o, 0);
        t_reset();
        t_ref_lead();
        t_fb_lead();
        t_simul();
        t_len_zero();
        t_repeat();
        t_pending();
        t_swap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule